// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles the control flow of one branch or jump instruction in a small integer core. Each accepted request carries the current program counter, both register operands, the sign-extended immediate, an operation select, the destination register index and two mode flags. The flags say whether compressed encodings are enabled and whether the current instruction is a short, two-byte one. From these, the block decides whether the transfer happens. It also produces the address to fetch next, the return address to write back, whether that write is allowed, and whether the instruction-address-misaligned exception applies.

One cycle after a request strobe, the result appears on registered outputs together with a single-cycle valid pulse. The block only flags a misaligned target. Redirecting to a trap handler is left to the surrounding core, and the block reports the faulting target address in the next-PC field so that the core can record it.

Alignment rules depend on the compressed-encoding flag. With it off, a target must be a multiple of four. With it on, only halfword alignment matters, and the unit never reports a fault.

Top module: `branch_resolve_unit`

## Requirements
- R1: The operation select `op` encodes 0 = equal, 1 = not equal, 2 = signed less than, 3 = signed greater or equal, 4 = unsigned less than, 5 = unsigned greater or equal (all comparing `rs1_val` with `rs2_val`), 6 = direct jump, and 7 = register-indirect jump.
- R2: A conditional branch whose condition holds, and which does not fault, sets `taken` and gives `next_pc` = `pc` + `imm`.
- R3: A conditional branch whose condition fails clears `taken` and gives `next_pc` equal to the sequential address. The sequential address is `pc` + 4, or `pc` + 2 when `short_insn` is 1.
- R4: A direct jump (op 6) that does not fault sets `taken`, gives `next_pc` = `pc` + `imm`, and gives `link_val` equal to the sequential address.
- R5: A register-indirect jump (op 7) uses `rs1_val` + `imm` with bit 0 forced to zero as its target, and gives `link_val` equal to the sequential address.
- R6: `link_we` is 1 only for a jump (op 6 or 7) that does not fault and whose `rd_idx` is nonzero. A destination index of zero, or any conditional branch, leaves `link_we` at 0.
- R7: With `rvc_en` = 0, a taken branch or direct jump whose target has either of its two low bits set raises `misalign`. In that case `taken` and `link_we` are 0, and `next_pc` holds the faulting target.
- R8: With `rvc_en` = 0, a register-indirect jump whose target (after bit 0 is cleared) has bit 1 set raises `misalign`. In that case `taken` and `link_we` are 0.
- R9: With `rvc_en` = 1, `misalign` is never raised, and the target of every taken transfer has bit 0 cleared.
- R10: The results for a request appear on the clock edge that samples `in_valid` = 1, with `out_valid` high for exactly that one cycle. In any cycle without a result, `out_valid`, `taken`, `link_we` and `misalign` are 0.
- R11: While reset is held, and after it is released until the first request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation select (see R1) |
| pc | input | XLEN | Address of the instruction being resolved |
| rs1_val | input | XLEN | First register operand |
| rs2_val | input | XLEN | Second register operand |
| imm | input | XLEN | Sign-extended immediate |
| rd_idx | input | REG_IDX_W | Destination register index |
| rvc_en | input | 1 | Compressed encodings enabled |
| short_insn | input | 1 | Current instruction is two bytes long |
| out_valid | output | 1 | Result valid pulse |
| taken | output | 1 | Control transfer performed |
| next_pc | output | XLEN | Next fetch address, or faulting target when misaligned |
| link_val | output | XLEN | Return address for the link write |
| link_we | output | 1 | Link write enable |
| misalign | output | 1 | Instruction-address-misaligned exception |

## Verification
The assertions assume that the request inputs are known and stable around the sampling edge whenever `in_valid` is high. They also assume that `short_insn` is only meaningful together with `rvc_en`, although the block accepts either combination. The stimulus changes inputs only on the falling edge and runs directed vectors for every condition, for both sides of each signed and unsigned boundary, and for each alignment fault. A block of random operations with random odd and even immediates follows. Idle cycles and back-to-back requests are interleaved so that the one-cycle pulse and the cleared flags between results are exercised.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [2:0] {
        BRU_EQ   = 3'd0,
        BRU_NE   = 3'd1,
        BRU_LT   = 3'd2,
        BRU_GE   = 3'd3,
        BRU_LTU  = 3'd4,
        BRU_GEU  = 3'd5,
        BRU_JAL  = 3'd6,
        BRU_JALR = 3'd7
    } bru_op_e;

    localparam int unsigned FULL_STEP  = 4;
    localparam int unsigned SHORT_STEP = 2;

endpackage

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  bru_op_e          op_i,
    input  logic [XLEN-1:0]  lhs_i,
    input  logic [XLEN-1:0]  rhs_i,
    output logic             go_o,
    output logic             is_jump_o
);
    logic eq_w;
    logic lt_s_w;
    logic lt_u_w;

    assign eq_w   = (lhs_i == rhs_i);
    assign lt_s_w = ($signed(lhs_i) < $signed(rhs_i));
    assign lt_u_w = (lhs_i < rhs_i);

    always_comb begin
        is_jump_o = 1'b0;
        unique case (op_i)
            BRU_EQ:   go_o = eq_w;
            BRU_NE:   go_o = !eq_w;
            BRU_LT:   go_o = lt_s_w;
            BRU_GE:   go_o = !lt_s_w;
            BRU_LTU:  go_o = lt_u_w;
            BRU_GEU:  go_o = !lt_u_w;
            BRU_JAL,
            BRU_JALR: begin
                go_o      = 1'b1;
                is_jump_o = 1'b1;
            end
            default:  go_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  bru_op_e          op_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [XLEN-1:0]  imm_i,
    input  logic             rvc_en_i,
    input  logic             short_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  tgt_pc_o,
    output logic             tgt_bad_o
);
    localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(FULL_STEP);
    localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(SHORT_STEP);

    logic [XLEN-1:0] base_w;
    logic [XLEN-1:0] sum_w;
    logic            clr_lsb_w;

    assign seq_pc_o  = pc_i + (short_i ? STEP_SHORT : STEP_FULL);
    assign base_w    = (op_i == BRU_JALR) ? rs1_i : pc_i;
    assign sum_w     = base_w + imm_i;
    assign clr_lsb_w = (op_i == BRU_JALR) || rvc_en_i;

    always_comb begin
        tgt_pc_o = sum_w;
        if (clr_lsb_w) begin
            tgt_pc_o[0] = 1'b0;
        end
        tgt_bad_o = !rvc_en_i && (tgt_pc_o[1:0] != 2'b00);
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            op,
    input  logic [XLEN-1:0]       pc,
    input  logic [XLEN-1:0]       rs1_val,
    input  logic [XLEN-1:0]       rs2_val,
    input  logic [XLEN-1:0]       imm,
    input  logic [REG_IDX_W-1:0]  rd_idx,
    input  logic                  rvc_en,
    input  logic                  short_insn,
    output logic                  out_valid,
    output logic                  taken,
    output logic [XLEN-1:0]       next_pc,
    output logic [XLEN-1:0]       link_val,
    output logic                  link_we,
    output logic                  misalign
);
    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] lnk;
        logic            lwe;
        logic            exc;
    } res_t;

    bru_op_e         op_w;
    logic            go_w;
    logic            is_jump_w;
    logic [XLEN-1:0] seq_pc_w;
    logic [XLEN-1:0] tgt_pc_w;
    logic            tgt_bad_w;
    res_t            res_d;
    res_t            res_q;

    assign op_w = bru_op_e'(op);

    bru_cond #(.XLEN(XLEN)) u_cond (
        .op_i      (op_w),
        .lhs_i     (rs1_val),
        .rhs_i     (rs2_val),
        .go_o      (go_w),
        .is_jump_o (is_jump_w)
    );

    bru_target #(.XLEN(XLEN)) u_target (
        .op_i      (op_w),
        .pc_i      (pc),
        .rs1_i     (rs1_val),
        .imm_i     (imm),
        .rvc_en_i  (rvc_en),
        .short_i   (short_insn),
        .seq_pc_o  (seq_pc_w),
        .tgt_pc_o  (tgt_pc_w),
        .tgt_bad_o (tgt_bad_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        res_d.tkn = 1'b0;
        res_d.lwe = 1'b0;
        res_d.exc = 1'b0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            res_d.lnk = seq_pc_w;
            if (go_w && tgt_bad_w) begin
                res_d.exc = 1'b1;
                res_d.npc = tgt_pc_w;
            end else if (go_w) begin
                res_d.tkn = 1'b1;
                res_d.npc = tgt_pc_w;
                res_d.lwe = is_jump_w && (rd_idx != '0);
            end else begin
                res_d.npc = seq_pc_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tkn;
    assign next_pc   = res_q.npc;
    assign link_val  = res_q.lnk;
    assign link_we   = res_q.lwe;
    assign misalign  = res_q.exc;

    p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!taken && !link_we));

    p_fault_jalr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rvc_en && op_w == BRU_JALR && tgt_pc_w[1]) |=> misalign);

    p_no_fault_rvc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rvc_en) |=> !misalign);

    p_zero_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx == '0) |=> !link_we);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    p_idle_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(taken || link_we || misalign));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((seq_pc_w - pc) == (short_insn ? XLEN'(2) : XLEN'(4))));
endmodule

// File: tb/branch_resolve_unit_tb_top.sv
module branch_resolve_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] pc = '0, rs1_val = '0, rs2_val = '0, imm = '0;
    logic [4:0]  rd_idx = '0;
    logic        rvc_en = 1'b0, short_insn = 1'b0;
    logic        out_valid, taken, link_we, misalign;
    logic [31:0] next_pc, link_val;

    int checks = 0;
    int fails  = 0;

    logic        e_vld, e_tkn, e_lwe, e_exc;
    logic [31:0] e_npc, e_lnk;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolve_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .pc(pc),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm), .rd_idx(rd_idx),
        .rvc_en(rvc_en), .short_insn(short_insn), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc), .link_val(link_val),
        .link_we(link_we), .misalign(misalign)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: plain reading of the requirements
    task automatic model(input int o, input logic [31:0] p, a, b, im,
                         input int rd, input bit rvc, input bit sh);
        logic [31:0] seq, tgt;
        bit go, bad;
        seq = sh ? p + 32'd2 : p + 32'd4;
        case (o)
            0: go = (a == b);
            1: go = (a != b);
            2: go = ($signed(a) < $signed(b));
            3: go = !($signed(a) < $signed(b));
            4: go = (a < b);
            5: go = !(a < b);
            default: go = 1;
        endcase
        if (o == 7) tgt = (a + im) & 32'hFFFF_FFFE;
        else        tgt = p + im;
        if (rvc) tgt = tgt & 32'hFFFF_FFFE;
        bad   = go && !rvc && (tgt[1:0] != 2'b00);
        e_vld = 1'b1;
        e_tkn = go && !bad;
        e_exc = bad;
        e_npc = go ? tgt : seq;
        e_lnk = seq;
        e_lwe = (o >= 6) && (rd != 0) && !bad;
    endtask

    task automatic step(input string req, input int o, input logic [31:0] p, a, b, im,
                        input int rd, input bit rvc, input bit sh);
        in_valid = 1'b1; op = 3'(o); pc = p; rs1_val = a; rs2_val = b; imm = im;
        rd_idx = 5'(rd); rvc_en = rvc; short_insn = sh;
        model(o, p, a, b, im, rd, rvc, sh);
        @(negedge clk);
        chk(req, "out_valid", 32'(out_valid), 32'(e_vld));
        chk(req, "taken",     32'(taken),     32'(e_tkn));
        chk(req, "misalign",  32'(misalign),  32'(e_exc));
        chk(req, "link_we",   32'(link_we),   32'(e_lwe));
        chk(req, "next_pc",   next_pc,        e_npc);
        chk(req, "link_val",  link_val,       e_lnk);
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0;
        op = 3'd6; rd_idx = 5'd3;
        @(negedge clk);
        chk(req, "idle out_valid", 32'(out_valid), 32'd0);
        chk(req, "idle taken",     32'(taken),     32'd0);
        chk(req, "idle link_we",   32'(link_we),   32'd0);
        chk(req, "idle misalign",  32'(misalign),  32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, during and after reset
        chk("R11", "rst out_valid", 32'(out_valid), 32'd0);
        chk("R11", "rst next_pc", next_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "post next_pc", next_pc, 32'd0);
        chk("R11", "post link_val", link_val, 32'd0);
        chk("R11", "post flags", 32'({out_valid, taken, link_we, misalign}), 32'd0);

        // R1 R2 R3: each condition on both outcomes
        step("R1_eq_R2",  0, 32'h100, 32'h5, 32'h5, 32'h40, 1, 0, 0);
        step("R1_eq_R3",  0, 32'h100, 32'h5, 32'h6, 32'h40, 1, 0, 0);
        step("R1_ne",     1, 32'h200, 32'h5, 32'h6, 32'hFFFF_FFF0, 0, 0, 0);
        step("R1_ne_no",  1, 32'h200, 32'h7, 32'h7, 32'h8, 0, 0, 0);
        step("R1_lt",     2, 32'h300, 32'hFFFF_FFFF, 32'h1, 32'h10, 0, 0, 0);
        step("R1_lt_no",  2, 32'h300, 32'h1, 32'hFFFF_FFFF, 32'h10, 0, 0, 0);
        step("R1_ge_eq",  3, 32'h300, 32'h8000_0000, 32'h8000_0000, 32'h20, 0, 0, 0);
        step("R1_ge_no",  3, 32'h300, 32'h8000_0000, 32'h7FFF_FFFF, 32'h20, 0, 0, 0);
        step("R1_ltu",    4, 32'h400, 32'h1, 32'hFFFF_FFF0, 32'h4, 0, 0, 0);
        step("R1_ltu_no", 4, 32'h400, 32'hFFFF_FFF0, 32'h1, 32'h4, 0, 0, 0);
        step("R1_geu",    5, 32'h400, 32'hFFFF_FFF0, 32'h1, 32'hC, 0, 0, 0);
        step("R1_geu_no", 5, 32'h400, 32'h0, 32'h1, 32'hC, 0, 0, 0);
        idle("R10");
        // R3 short sequential step
        step("R3_short", 0, 32'h500, 32'h1, 32'h2, 32'h8, 0, 1, 1);
        // R4 direct jump, R6 link control
        step("R4_jal",     6, 32'h600, 32'h0, 32'h0, 32'h100, 1, 0, 0);
        step("R6_jal_x0",  6, 32'h600, 32'h0, 32'h0, 32'h100, 0, 0, 0);
        step("R6_branch",  0, 32'h600, 32'h3, 32'h3, 32'h8, 9, 0, 0);
        // R5 indirect jump clears bit 0
        step("R5_jalr",    7, 32'h700, 32'h1001, 32'h0, 32'h4, 5, 0, 0);
        step("R5_jalr_neg",7, 32'h700, 32'h2000, 32'h0, 32'hFFFF_FFFD, 2, 0, 1);
        // R8 bit 1 fault
        step("R8_jalr",    7, 32'h700, 32'h1002, 32'h0, 32'h0, 5, 0, 0);
        step("R8_jalr_odd",7, 32'h700, 32'h1003, 32'h0, 32'h0, 5, 0, 0);
        // R7 branch and jump faults
        step("R7_branch",  0, 32'h800, 32'h1, 32'h1, 32'h6, 0, 0, 0);
        step("R7_jal",     6, 32'h800, 32'h0, 32'h0, 32'h2, 4, 0, 0);
        step("R7_notaken", 0, 32'h800, 32'h1, 32'h2, 32'h6, 0, 0, 0);
        idle("R10");
        // R9 compressed mode: no fault
        step("R9_branch",  0, 32'h900, 32'h1, 32'h1, 32'h6, 0, 1, 0);
        step("R9_jalr",    7, 32'h900, 32'h1002, 32'h0, 32'h1, 6, 1, 1);
        step("R9_jal_odd", 6, 32'h900, 32'h0, 32'h0, 32'h3, 6, 1, 0);
        idle("R10");
        idle("R10");

        // mixed random operations, R1 to R9
        for (int i = 0; i < 200; i++) begin
            int o;
            o = $urandom_range(0, 7);
            step("R1_R9_rand", o, $urandom & 32'hFFFF_FFFC,
                 ($urandom_range(0, 3) == 0) ? 32'h55 : $urandom,
                 ($urandom_range(0, 3) == 0) ? 32'h55 : $urandom,
                 32'($signed($urandom_range(0, 2047)) - 1024),
                 $urandom_range(0, 3), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 4) == 0) idle("R10");
        end
        idle("R10");
        summary();
        $finish;
    end
endmodule